// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Front End

This block is the synchronous front end of a static RAM that uses a late-write protocol, together with a behavioural storage array. Select, write enable, per-lane write enables and address are registered on the rising clock edge. The write data for a write command comes one cycle later and is parked in a single-entry pending-write buffer. That buffer is retired into the array when the next write delivers its own data. Reads compare their address with the pending entry. On a match they return the buffered lanes merged over the array word, so a read never sees stale data.

Read data goes through an output register that holds its value until another read replaces it. The data bus is modelled as a separate input, output and drive-enable. The drive-enable is cut at once by the output-enable input or by the sleep input. It is also cut by the pipeline during deselect cycles and during the data cycle of a write. Sleep also blocks new commands.

Top module: `late_write_sram`

## Requirements
- R1: A word is 36 bits in four 9-bit lanes, lane i being bits 9i+8 down to 9i. A write updates exactly the lanes whose `bw_ni[i]` bit is 0, for any of the 16 combinations.
- R2: A command is taken on a rising edge when `sel_ni` is 0 and `sleep_i` is 0. `we_ni` = 0 makes it a write and `we_ni` = 1 makes it a read.
- R3: The data of a write command taken at edge n is the value of `dq_i` at edge n+1.
- R4: A write stays pending until the next write's data is taken, and is then stored in the array. A read whose full address equals the pending address returns the pending lanes merged over the array word.
- R5: For a read taken at edge n, `dq_o` carries the read word from edge n+1 to edge n+2, and `dq_oe_o` is 1 in that cycle unless another rule forces it to 0.
- R6: `dq_o` keeps the last read word while no read result is loaded.
- R7: A rising edge with `sel_ni` = 1 is a dead cycle: nothing is read or written, and `dq_oe_o` is 0 in the output cycle that would belong to it.
- R8: After a write command at edge n, `dq_oe_o` is 0 from edge n to edge n+2. This also drops the result of a read taken at edge n-1.
- R9: `oe_ni` = 1 forces `dq_oe_o` to 0 at once, without waiting for a clock edge.
- R10: `sleep_i` = 1 forces `dq_oe_o` to 0 at once, and commands sampled while it is 1 are ignored.
- R11: The address has `ADDR_W` bits (19 by default). The array uses the low `MEM_AW` bits, while the pending-write match uses all `ADDR_W` bits.
- R12: Under reset `dq_oe_o` is 0, `dq_o` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all commands taken on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep: bus released, commands ignored |
| sel_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write enable, active low |
| bw_ni | input | 4 | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_i | input | 36 | Write data from the bus |
| dq_o | output | 36 | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
A read taken at edge n is due on the bus from edge n+1 to edge n+2. A write's data is sampled at edge n+1, and the bus is released from edge n to edge n+2. The bench model applies write data and computes read results in the edge order the requirements give. It compares the drive enable and the data a few nanoseconds after each rising edge, so each result is checked in its own cycle. The asynchronous output-enable and sleep paths are also checked in the middle of a cycle, right after the input changes, with no clock edge in between.

// File: rtl/late_wr_pkg.sv
package late_wr_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_mask_t;
endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage
  import late_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              sel_ni,
  input  logic              we_ni,
  input  lane_mask_t        bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_q_o,
  output logic              wr_q_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output lane_mask_t        mask_q_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic go;
  assign go = !sel_ni && !sleep_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q_o   <= 1'b0;
      wr_q_o   <= 1'b0;
      addr_q_o <= '0;
      mask_q_o <= '0;
    end else begin
      rd_q_o   <= go && we_ni;
      wr_q_o   <= go && !we_ni;
      addr_q_o <= addr_i;
      mask_q_o <= ~bw_ni;
    end
  end
endmodule

// File: rtl/lw_write_buf.sv
module lw_write_buf
  import late_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_q_i,
  input  logic [ADDR_W-1:0] addr_q_i,
  input  lane_mask_t        mask_q_i,
  input  word_t             din_i,
  output logic              commit_o,
  output logic              pend_v_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output lane_mask_t        pend_mask_o,
  output word_t             pend_data_o
);
  timeunit 1ns;
  timeprecision 1ps;

  // old entry retires on the edge that brings the new entry's data
  assign commit_o = wr_q_i && pend_v_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_v_o    <= 1'b0;
      pend_addr_o <= '0;
      pend_mask_o <= '0;
      pend_data_o <= '0;
    end else if (wr_q_i) begin
      pend_v_o    <= 1'b1;
      pend_addr_o <= addr_q_i;
      pend_mask_o <= mask_q_i;
      pend_data_o <= din_i;
    end
  end
endmodule

// File: rtl/lw_mem_array.sv
module lw_mem_array
  import late_wr_pkg::*;
#(
  parameter int unsigned MEM_AW = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [MEM_AW-1:0] waddr_i,
  input  lane_mask_t        wmask_i,
  input  word_t             wdata_i,
  input  logic [MEM_AW-1:0] raddr_i,
  output word_t             rdata_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned DEPTH = 1 << MEM_AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && wmask_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/lw_read_path.sv
module lw_read_path
  import late_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_q_i,
  input  logic              wr_q_i,
  input  logic [ADDR_W-1:0] addr_q_i,
  input  word_t             arr_data_i,
  input  logic              pend_v_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  lane_mask_t        pend_mask_i,
  input  word_t             pend_data_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  output word_t             dq_o,
  output logic              dq_oe_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic  hit;
  word_t merged;
  logic  rd_v_q;
  word_t out_q;

  assign hit = pend_v_i && (pend_addr_i == addr_q_i);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_W +: LANE_W] = (hit && pend_mask_i[g])
                                        ? pend_data_i[g*LANE_W +: LANE_W]
                                        : arr_data_i[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_v_q <= 1'b0;
      out_q  <= '0;
    end else begin
      rd_v_q <= rd_q_i;
      if (rd_q_i) out_q <= merged;
    end
  end

  assign dq_o    = out_q;
  // wr_q_i marks the write data cycle: the bus belongs to the host
  assign dq_oe_o = rd_v_q && !wr_q_i && !oe_ni && !sleep_i;
endmodule

// File: rtl/late_write_sram.sv
module late_write_sram
  import late_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned MEM_AW = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sleep_i,
  input  logic                     sel_ni,
  input  logic                     we_ni,
  input  logic [LANES-1:0]         bw_ni,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     oe_ni,
  input  logic [WORD_W-1:0]        dq_i,
  output logic [WORD_W-1:0]        dq_o,
  output logic                     dq_oe_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned IDX_W = (MEM_AW < ADDR_W) ? MEM_AW : ADDR_W;

  logic              rd_q, wr_q, commit, pend_v;
  logic [ADDR_W-1:0] addr_q, pend_addr;
  lane_mask_t        mask_q, pend_mask;
  word_t             pend_data, arr_data;

  lw_cmd_stage #(.ADDR_W(ADDR_W)) i_cmd (
    .clk_i, .rst_ni, .sleep_i, .sel_ni, .we_ni, .bw_ni, .addr_i,
    .rd_q_o(rd_q), .wr_q_o(wr_q), .addr_q_o(addr_q), .mask_q_o(mask_q)
  );

  lw_write_buf #(.ADDR_W(ADDR_W)) i_wbuf (
    .clk_i, .rst_ni, .wr_q_i(wr_q), .addr_q_i(addr_q), .mask_q_i(mask_q),
    .din_i(dq_i), .commit_o(commit), .pend_v_o(pend_v),
    .pend_addr_o(pend_addr), .pend_mask_o(pend_mask), .pend_data_o(pend_data)
  );

  lw_mem_array #(.MEM_AW(IDX_W)) i_mem (
    .clk_i, .we_i(commit), .waddr_i(pend_addr[IDX_W-1:0]),
    .wmask_i(pend_mask), .wdata_i(pend_data),
    .raddr_i(addr_q[IDX_W-1:0]), .rdata_o(arr_data)
  );

  lw_read_path #(.ADDR_W(ADDR_W)) i_rd (
    .clk_i, .rst_ni, .rd_q_i(rd_q), .wr_q_i(wr_q), .addr_q_i(addr_q),
    .arr_data_i(arr_data), .pend_v_i(pend_v), .pend_addr_i(pend_addr),
    .pend_mask_i(pend_mask), .pend_data_i(pend_data),
    .oe_ni, .sleep_i, .dq_o, .dq_oe_o
  );
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
  import late_wr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_i,
  input logic              sel_ni,
  input logic              we_ni,
  input logic              oe_ni,
  input logic [WORD_W-1:0] dq_o,
  input logic              dq_oe_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic rd_cmd, wr_cmd;
  assign rd_cmd = !sel_ni && !sleep_i && we_ni;
  assign wr_cmd = !sel_ni && !sleep_i && !we_ni;

  p_sleep_hiz_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);

  p_oe_hiz_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

  p_dead_hiz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> ##1 !dq_oe_o);

  p_turn_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |=> !dq_oe_o ##1 !dq_oe_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_cmd, 2) |-> $stable(dq_o));
endmodule

bind late_write_sram lw_sram_chk i_lw_sram_chk (.*);

// File: tb/test_late_write_sram.sv
module test_late_write_sram;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 19;
  localparam int MW = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni, sleep_i, sel_ni, we_ni, oe_ni;
  logic [3:0]    bw_ni;
  logic [AW-1:0] addr_i;
  logic [35:0]   dq_i, dq_o;
  logic          dq_oe_o;

  always #10 clk_i = ~clk_i;

  late_write_sram #(.ADDR_W(AW), .MEM_AW(MW)) i_late_write_sram (
    .clk_i, .rst_ni, .sleep_i, .sel_ni, .we_ni, .bw_ni, .addr_i,
    .oe_ni, .dq_i, .dq_o, .dq_oe_o
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  logic [35:0]   m_mem [1024];
  logic          pv;
  logic [AW-1:0] pa;
  logic [3:0]    pm;
  logic [35:0]   pd;
  logic          rdp, wrp, dph, exp_v;
  logic [AW-1:0] wrp_a;
  logic [3:0]    wrp_m;
  logic [35:0]   rd_val, exp_q;

  function automatic logic [35:0] pat(int k);
    return 36'h5A5A5A5A5 ^ (36'(k) * 36'h01234567);
  endfunction

  function automatic logic [35:0] m_read(logic [AW-1:0] a);
    logic [35:0] w = m_mem[a[MW-1:0]];
    if (pv && pa == a)
      for (int g = 0; g < 4; g++) if (pm[g]) w[g*9 +: 9] = pd[g*9 +: 9];
    return w;
  endfunction

  task automatic check(string tag);
    logic eo;
    eo = exp_v && !dph && !oe_ni && !sleep_i;
    checks++;
    if (dq_oe_o !== eo) begin
      errors++;
      $display("FAIL %s dq_oe_o act %0b exp %0b", tag, dq_oe_o, eo);
    end
    checks++;
    if (dq_o !== exp_q) begin
      errors++;
      $display("FAIL %s dq_o act %h exp %h", tag, dq_o, exp_q);
    end
  endtask

  task automatic issue(logic s_n, logic w_n, logic [3:0] b_n, logic [AW-1:0] a,
                       logic [35:0] d, string tag);
    logic go;
    sel_ni = s_n; we_ni = w_n; bw_ni = b_n; addr_i = a; dq_i = d;
    @(posedge clk_i);
    go = !s_n && !sleep_i;
    if (rdp) begin exp_q = rd_val; exp_v = 1'b1; end else exp_v = 1'b0;
    if (wrp) begin
      if (pv)
        for (int g = 0; g < 4; g++)
          if (pm[g]) m_mem[pa[MW-1:0]][g*9 +: 9] = pd[g*9 +: 9];
      pv = 1'b1; pa = wrp_a; pm = wrp_m; pd = d;
    end
    dph = go && !w_n;
    rdp = go && w_n;
    if (rdp) rd_val = m_read(a);
    wrp = dph; wrp_a = a; wrp_m = ~b_n;
    #4;
    check(tag);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [3:0] b_n, logic [35:0] d, string tag);
    issue(1'b0, 1'b0, b_n, a, d, tag);
  endtask
  task automatic rd(logic [AW-1:0] a, logic [35:0] d, string tag);
    issue(1'b0, 1'b1, 4'hF, a, d, tag);
  endtask
  task automatic idle(logic [35:0] d, string tag);
    issue(1'b1, 1'b1, 4'hF, '0, d, tag);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; sleep_i = 0; sel_ni = 1; we_ni = 1; oe_ni = 0;
    bw_ni = 4'hF; addr_i = '0; dq_i = '0;
    pv = 0; pa = '0; pm = '0; pd = '0; rdp = 0; wrp = 0; dph = 0; exp_v = 0;
    wrp_a = '0; wrp_m = '0; rd_val = '0; exp_q = '0;
    for (int i = 0; i < 1024; i++) m_mem[i] = '0;
    repeat (3) @(posedge clk_i);
    #4 check("R12 reset");
    @(negedge clk_i); rst_ni = 1;

    // R3 R4: back-to-back full writes, then read of the pending address
    wr(1, 4'h0, 36'h0, "R3 wr1");
    wr(2, 4'h0, pat(1), "R3 wr2");
    wr(3, 4'h0, pat(2), "R3 wr3");
    wr(4, 4'h0, pat(3), "R3 wr4");
    rd(4, pat(4), "R4 rd pending");
    rd(1, 36'h0, "R5 rd1");
    rd(2, 36'h0, "R5 rd2");
    rd(3, 36'h0, "R5 rd3");
    idle(36'h0, "R5 last");
    idle(36'h0, "R6 hold1");
    idle(36'h0, "R6 hold2");

    // R1: every lane mask on addr 5, each read straight from the buffer
    wr(5, 4'h0, 36'h0, "R1 base");
    for (int m = 0; m < 16; m++) begin
      wr(5, 4'(m), (m == 0) ? pat(50) : pat(60 + m - 1), "R1 mask wr");
      rd(5, pat(60 + m), "R1 mask merge");
      idle(36'h0, "R1 mask out");
    end
    wr(6, 4'h0, 36'h0, "R4 retire");
    rd(5, pat(6), "R4 rd array");
    idle(36'h0, "R4 out");

    // R7: deselect between reads
    rd(1, 36'h0, "R7 rd");
    idle(36'h0, "R7 dead");
    idle(36'h0, "R7 hiz");
    rd(2, 36'h0, "R7 rd2");
    idle(36'h0, "R7 out2");

    // R8: read immediately followed by write
    rd(3, 36'h0, "R8 rd");
    wr(7, 4'h0, 36'h0, "R8 turn");
    idle(pat(7), "R8 data");
    rd(7, 36'h0, "R8 rd7");
    idle(36'h0, "R8 out7");

    // R9: asynchronous output enable
    rd(4, 36'h0, "R9 rd");
    idle(36'h0, "R9 drive");
    oe_ni = 1; #1 check("R9 oe off");
    oe_ni = 0; #1 check("R9 oe on");

    // R10: sleep ignores commands and releases bus
    rd(2, 36'h0, "R10 rd");
    idle(36'h0, "R10 drive");
    sleep_i = 1; #1 check("R10 sleep hiz");
    wr(2, 4'h0, 36'h0, "R10 wr ignored");
    idle(36'hFFFFFFFFF, "R10 no data");
    sleep_i = 0;
    rd(2, 36'h0, "R10 rd old");
    idle(36'h0, "R10 out old");

    // R11: full-width match, low-bit array index
    wr(9, 4'h0, 36'h0, "R11 wr9");
    wr(AW'(19'h01009), 4'h0, pat(90), "R11 wr alias");
    rd(9, pat(91), "R11 no bypass");
    idle(36'h0, "R11 out");
    wr(8, 4'h0, 36'h0, "R11 retire");
    rd(9, pat(92), "R11 alias read");
    idle(36'h0, "R11 alias out");
    rd(AW'(19'h01009), 36'h0, "R11 full read");
    idle(36'h0, "R11 full out");
    idle(36'h0, "R2 end");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule